// File: doc/BRIEF.md
# Framed Serial Codec Port

This block is the device end of a synchronous, bidirectional serial link between a host processor and the digital side of a modem analog front end. The host supplies a bit clock, a one-clock frame-sync pulse and serial input data. The block returns serial output data. Every 16-bit frame is either a data frame or a control frame. A data frame hands one transmit sample to the converter side and sends one receive sample back to the host. A control frame reads or writes one entry of a small internal bank of 8-bit settings registers.

The frame type is not marked on the wire, so both ends have to agree on it by following the same rules. In the default software-selected mode, every frame is a data frame unless the host set the least significant bit of the previous data word. In hardware-selected mode, which is turned on by a bit in register 1, data and control frames strictly alternate. Writing that mode bit to zero in two consecutive frames puts both ends back in step, whichever frame type the device expected at the time. The serial inputs are brought into the system clock domain and their edges are detected there.

Top module: `fcp_port`

## Requirements
- R1: A frame begins on the serial clock falling edge at which frame sync is seen high. The next 16 falling edges sample input bits, most significant bit first. Output bits change only on serial clock rising edges, and a data frame sends `rx_word` (captured at frame start) most significant bit first.
- R2: In software mode every frame is a data frame, except that a data word whose bit 0 is 1 makes the next frame a control frame. At the end of each data frame the full received word appears on `tx_word`, with a one-cycle pulse on `tx_valid`.
- R3: An input control frame carries, in order, a direction bit (1 = read, 0 = write), address bits 6 down to 0, and data bits 7 down to 0. A write stores the data into the addressed register.
- R4: An output control frame sends eight zero bits, followed by the addressed register's value (most significant bit first) for a read, or by eight zero bits for a write.
- R5: While bit 0 of register 1 is 1, frames alternate: a control frame always follows a data frame, and a data frame always follows a control frame.
- R6: Two consecutive frames carrying the word 0x0100 (a write of 0x00 to register 1) leave the port in software mode, expecting a data frame, from either frame alignment.
- R7: After reset, `sdout` and `tx_word` are 0, and the registers read 0x00=0x08, 0x01=0x00, 0x02=0xFF, 0x03=0xFF, 0x06=0x50, 0x09=0x0A, 0x0A=0x22, 0x0B=0x12, 0x0D=0xC0, with all others at 0x00.
- R8: Writes to addresses 4, 5 and 15 and above are ignored. Reads of those addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial bit clock from the host |
| fsync | input | 1 | One-bit-wide frame-sync pulse, one bit before the first bit |
| sdin | input | 1 | Serial data from the host |
| sdout | output | 1 | Serial data to the host |
| rx_word | input | 16 | Receive sample from the converter side, sent in data frames |
| tx_word | output | 16 | Last transmit sample received in a data frame |
| tx_valid | output | 1 | One-cycle pulse when `tx_word` is updated |

## Verification
The hardest case to reach is losing frame alignment while in hardware-selected mode. The recovery word must then arrive first in a data slot in one case and first in a control slot in the other. The stimulus enters alternating mode through a control write, then sends the double clear directly. Later it re-enters the mode and adds one data frame so that the clear starts on the opposite slot. After each recovery, plain data frames confirm that the port returns the receive sample rather than register contents. Random register traffic, together with writes to the ignored addresses, exercises the control path.

// File: rtl/fcp_pkg.sv
package fcp_pkg;

   typedef enum logic {
      SLOT_DATA = 1'b0,
      SLOT_CTRL = 1'b1
   } slot_e;

   // power-up contents of the settings bank
   function automatic logic [7:0] fcp_reset_value(input int unsigned idx);
      case (idx)
         0:       return 8'h08;
         2, 3:    return 8'hFF;
         6:       return 8'h50;
         9:       return 8'h0A;
         10:      return 8'h22;
         11:      return 8'h12;
         13:      return 8'hC0;
         default: return 8'h00;
      endcase
   endfunction

   // entries 4 and 5 are held at their reset value
   function automatic bit fcp_writable(input int unsigned idx, input int unsigned nregs);
      return (idx < nregs) && (idx != 4) && (idx != 5);
   endfunction

endpackage

// File: rtl/fcp_sync.sv
module fcp_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic fs_i,
   input  logic sd_i,
   output logic sck_rise,
   output logic sck_fall,
   output logic fs_o,
   output logic sd_o
);
   logic [2:0] raw;
   logic [2:0] synced;
   logic       sclk_prev;

   assign raw = {sclk_i, fs_i, sd_i};

   generate
      if (STAGES == 0) begin : g_bypass
         assign synced = raw;
      end else begin : g_chain
         logic [2:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < STAGES; k++) pipe[k] <= '0;
            end else begin
               pipe[0] <= raw;
               for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
            end
         end
         assign synced = pipe[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev <= 1'b0;
      else        sclk_prev <= synced[2];
   end

   assign sck_rise = synced[2] & ~sclk_prev;
   assign sck_fall = ~synced[2] & sclk_prev;
   assign fs_o     = synced[1];
   assign sd_o     = synced[0];
endmodule

// File: rtl/fcp_regs.sv
module fcp_regs
   import fcp_pkg::*;
#(
   parameter int unsigned NUM_REGS = 15,
   parameter int unsigned ADDR_W   = 7,
   parameter int unsigned REG_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [REG_W-1:0]  wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [REG_W-1:0]  rdata,
   output logic              hc_mode
);
   logic [REG_W-1:0] regs [NUM_REGS];

   generate
      if (REG_W != 8) begin : g_bad_width
         $error("fcp_regs: reset table is defined for 8-bit entries");
      end
      if (NUM_REGS < 2 || NUM_REGS > (1 << ADDR_W)) begin : g_bad_depth
         $error("fcp_regs: NUM_REGS out of range");
      end
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         if (fcp_writable(i, NUM_REGS)) begin : g_rw
            logic [REG_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                          q <= REG_W'(fcp_reset_value(i));
               else if (we && waddr == ADDR_W'(i)) q <= wdata;
            end
            assign regs[i] = q;
         end else begin : g_ro
            assign regs[i] = REG_W'(fcp_reset_value(i));
         end
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (raddr == ADDR_W'(i)) rdata = regs[i];
      end
   end

   assign hc_mode = regs[1][0];
endmodule

// File: rtl/fcp_port.sv
module fcp_port
   import fcp_pkg::*;
#(
   parameter int unsigned WORD_W      = 16,
   parameter int unsigned ADDR_W      = 7,
   parameter int unsigned REG_W       = 8,
   parameter int unsigned NUM_REGS    = 15,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              fsync,
   input  logic              sdin,
   output logic              sdout,
   input  logic [WORD_W-1:0] rx_word,
   output logic [WORD_W-1:0] tx_word,
   output logic              tx_valid
);
   localparam int unsigned CNT_W = $clog2(WORD_W);
   localparam int unsigned HDR_BITS = 1 + ADDR_W;
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
   localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_BITS - 1);

   generate
      if (WORD_W != 1 + ADDR_W + REG_W) begin : g_bad_frame
         $error("fcp_port: WORD_W must equal 1 + ADDR_W + REG_W");
      end
   endgenerate

   logic              sck_rise, sck_fall, fs_s, sd_s;
   logic              active;
   logic [CNT_W-1:0]  bit_cnt;
   logic [WORD_W-2:0] in_sr;
   logic [WORD_W-1:0] out_sr;
   logic [WORD_W-1:0] word_full;
   logic              sdout_q;
   slot_e             cur_slot, next_slot;
   logic              hc_mode;
   logic [ADDR_W-1:0] hdr_addr;
   logic              hdr_rd;
   logic [REG_W-1:0]  rd_data;
   logic              reg_we;

   fcp_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n),
      .sclk_i(sclk), .fs_i(fsync), .sd_i(sdin),
      .sck_rise(sck_rise), .sck_fall(sck_fall), .fs_o(fs_s), .sd_o(sd_s)
   );

   // word as it stands once the current bit is shifted in
   assign word_full = {in_sr, sd_s};
   assign hdr_addr  = {in_sr[ADDR_W-2:0], sd_s};
   assign hdr_rd    = in_sr[ADDR_W-1];

   assign reg_we = sck_fall && !fs_s && active && (bit_cnt == LAST_BIT)
                   && (cur_slot == SLOT_CTRL) && !word_full[WORD_W-1];

   fcp_regs #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .REG_W(REG_W)) i_regs (
      .clk(clk), .rst_n(rst_n),
      .we(reg_we),
      .waddr(word_full[WORD_W-2 -: ADDR_W]),
      .wdata(word_full[REG_W-1:0]),
      .raddr(hdr_addr),
      .rdata(rd_data),
      .hc_mode(hc_mode)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         bit_cnt   <= '0;
         in_sr     <= '0;
         out_sr    <= '0;
         sdout_q   <= 1'b0;
         cur_slot  <= SLOT_DATA;
         next_slot <= SLOT_DATA;
         tx_word   <= '0;
         tx_valid  <= 1'b0;
      end else begin
         tx_valid <= 1'b0;
         if (sck_fall) begin
            if (fs_s) begin
               active   <= 1'b1;
               bit_cnt  <= '0;
               cur_slot <= next_slot;
               out_sr   <= (next_slot == SLOT_CTRL) ? '0 : rx_word;
            end else if (active) begin
               in_sr   <= word_full[WORD_W-2:0];
               bit_cnt <= bit_cnt + CNT_W'(1);
               if (cur_slot == SLOT_CTRL && bit_cnt == HDR_LAST) begin
                  out_sr <= {(hdr_rd ? rd_data : {REG_W{1'b0}}),
                             {(WORD_W-REG_W){1'b0}}};
               end
               if (bit_cnt == LAST_BIT) begin
                  active <= 1'b0;
                  if (cur_slot == SLOT_CTRL) begin
                     next_slot <= SLOT_DATA;
                  end else begin
                     tx_word   <= word_full;
                     tx_valid  <= 1'b1;
                     next_slot <= (hc_mode || word_full[0]) ? SLOT_CTRL : SLOT_DATA;
                  end
               end
            end
         end else if (sck_rise) begin
            if (active) begin
               sdout_q <= out_sr[WORD_W-1];
               out_sr  <= {out_sr[WORD_W-2:0], 1'b0};
            end else begin
               sdout_q <= 1'b0;
            end
         end
      end
   end

   assign sdout = sdout_q;
endmodule

// File: rtl/fcp_port_chk.sv
module fcp_port_chk (
   input logic clk,
   input logic rst_n,
   input logic sck_rise,
   input logic sdout,
   input logic tx_valid,
   input logic tx_lsb,
   input logic hc_mode,
   input logic ctrl_now,
   input logic ctrl_next,
   input logic active
);
   // R1: serial output only moves after a detected rising edge
   a_r1_sdout_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sdout) |-> $past(sck_rise));

   // R2: transmit samples come only out of data frames
   a_r2_valid_from_data: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !ctrl_now);

   // R2: tx_valid is a single-cycle pulse
   a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |=> !tx_valid);

   // R2: in software mode the word's bit 0 selects the next frame type
   a_r2_sw_request: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !hc_mode) |-> (ctrl_next == tx_lsb));

   // R5: in hardware mode a control frame follows every data frame
   a_r5_hw_ctrl_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && hc_mode) |-> ctrl_next);

   // R5: a control frame is never followed by another one
   a_r5_data_after_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(active) && ctrl_now) |-> !ctrl_next);
endmodule

bind fcp_port fcp_port_chk i_chk (
   .clk(clk),
   .rst_n(rst_n),
   .sck_rise(sck_rise),
   .sdout(sdout),
   .tx_valid(tx_valid),
   .tx_lsb(tx_word[0]),
   .hc_mode(hc_mode),
   .ctrl_now(cur_slot == fcp_pkg::SLOT_CTRL),
   .ctrl_next(next_slot == fcp_pkg::SLOT_CTRL),
   .active(active)
);

// File: tb/test_fcp_port.sv
module test_fcp_port;
   localparam int H = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0;
   logic        fsync = 1'b0;
   logic        sdin = 1'b0;
   logic        sdout;
   logic [15:0] rx_word = '0;
   logic [15:0] tx_word;
   logic        tx_valid;

   int total = 0;
   int bad = 0;

   logic [7:0] m_reg [0:14];
   bit         m_ctrl_next;

   always #10 clk = ~clk;

   fcp_port i_fcp_port (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .fsync(fsync), .sdin(sdin),
      .sdout(sdout), .rx_word(rx_word), .tx_word(tx_word), .tx_valid(tx_valid)
   );

   function automatic logic [7:0] dflt(input int a);
      case (a)
         0: return 8'h08;  2: return 8'hFF;  3: return 8'hFF;
         6: return 8'h50;  9: return 8'h0A;  10: return 8'h22;
         11: return 8'h12; 13: return 8'hC0;
         default: return 8'h00;
      endcase
   endfunction

   function automatic bit can_write(input int a);
      return a < 15 && a != 4 && a != 5;
   endfunction

   function automatic logic [7:0] m_read(input int a);
      return (a < 15) ? m_reg[a] : 8'h00;
   endfunction

   task automatic check(input bit ok, input string req, input logic [15:0] act,
                        input logic [15:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic run_frame(input logic [15:0] din, input string req);
      logic [15:0] rx;
      logic [15:0] got;
      logic [15:0] exp;
      bit          is_ctrl;
      int          a;
      rx = 16'($urandom);
      is_ctrl = m_ctrl_next;
      a = int'(din[14:8]);
      if (is_ctrl) exp = din[15] ? {8'h00, m_read(a)} : 16'h0000;
      else         exp = rx;
      rx_word = rx;
      // sync bit
      sclk = 1'b1; fsync = 1'b1; tick(H);
      sclk = 1'b0; tick(H);
      fsync = 1'b0;
      for (int i = 15; i >= 0; i--) begin
         sclk = 1'b1; sdin = din[i]; tick(H);
         got[i] = sdout;
         sclk = 1'b0; tick(H);
      end
      tick(6);
      check(got === exp, req, got, exp);
      if (is_ctrl) begin
         if (!din[15] && can_write(a)) m_reg[a] = din[7:0];
         m_ctrl_next = 1'b0;
      end else begin
         check(tx_word === din, "R2", tx_word, din);
         m_ctrl_next = m_reg[1][0] | din[0];
      end
   endtask

   task automatic ctrl_access(input bit rd, input int a, input logic [7:0] d,
                              input string req);
      run_frame(16'($urandom) | 16'h0001, "R2");
      run_frame({rd, 7'(a), d}, req);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h5EED_0A17));
      for (int a = 0; a < 15; a++) m_reg[a] = dflt(a);
      m_ctrl_next = 1'b0;
      tick(10);
      rst_n = 1'b1;
      tick(4);
      // R7: ports after reset
      check(sdout === 1'b0, "R7", {15'h0, sdout}, 16'h0);
      check(tx_word === 16'h0, "R7", tx_word, 16'h0);

      // R7: reset contents of every register
      for (int a = 0; a < 15; a++) ctrl_access(1'b1, a, 8'h00, "R7");

      // R1 / R2: software mode, data frames only
      for (int n = 0; n < 20; n++) run_frame(16'($urandom) & 16'hFFFE, "R1");

      // R3 / R4: random writes and reads
      for (int n = 0; n < 40; n++) begin
         int  a;
         bit  rd;
         a  = int'($urandom_range(0, 14));
         rd = 1'($urandom);
         if (a == 1) rd = 1'b1;
         ctrl_access(rd, a, 8'($urandom), rd ? "R4" : "R3");
      end
      for (int a = 0; a < 15; a++) ctrl_access(1'b1, a, 8'h00, "R3");

      // R8: ignored addresses
      ctrl_access(1'b0, 4, 8'hA5, "R8");
      ctrl_access(1'b0, 5, 8'h3C, "R8");
      ctrl_access(1'b0, 15, 8'h77, "R8");
      ctrl_access(1'b0, 127, 8'hEE, "R8");
      ctrl_access(1'b1, 4, 8'h00, "R8");
      ctrl_access(1'b1, 5, 8'h00, "R8");
      ctrl_access(1'b1, 15, 8'h00, "R8");
      ctrl_access(1'b1, 127, 8'h00, "R8");

      // R5: enter alternating mode, then random traffic
      ctrl_access(1'b0, 1, 8'h01, "R3");
      for (int n = 0; n < 30; n++) begin
         logic [15:0] w;
         w = 16'($urandom);
         if (m_ctrl_next) begin
            int a;
            a = int'($urandom_range(0, 14));
            if (a == 1) w[15] = 1'b1;
            w[14:8] = 7'(a);
         end
         run_frame(w, "R5");
      end

      // R6: double clear starting in a data slot
      if (m_ctrl_next) run_frame({1'b1, 7'd2, 8'h00}, "R5");
      run_frame(16'h0100, "R6");
      run_frame(16'h0100, "R6");
      for (int n = 0; n < 3; n++) run_frame(16'($urandom) & 16'hFFFE, "R6");

      // R6: double clear starting in a control slot
      ctrl_access(1'b0, 1, 8'h01, "R3");
      run_frame(16'($urandom) & 16'hFFFE, "R5");
      run_frame(16'h0100, "R6");
      run_frame(16'h0100, "R6");
      for (int n = 0; n < 3; n++) run_frame(16'($urandom) & 16'hFFFE, "R6");
      ctrl_access(1'b1, 1, 8'h00, "R6");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule